// File: doc/BRIEF.md
# SMBus Slave Receive Engine with Selectable Acknowledge

This block is the receive side of a two-wire bus slave. It oversamples the clock and data lines with the system clock and detects START and STOP conditions. It shifts in the address byte, most significant bit first, with the data line sampled on each rising clock edge. The lowest bit of the address byte is the direction bit.

When a write to this slave is seen, the block receives any number of data bytes until a STOP. A written address is compared with a programmable address, but only in the bit positions that a programmable mask enables.

The acknowledge bit is produced in one of two ways, chosen by a mode input:

- **Hardware mode.** The block drives ACK or NACK itself and posts its interrupt after the ACK clock.
- **Software mode.** The block posts its interrupt and an acknowledge request before the ACK clock. It holds the clock line low until software supplies the acknowledge value and clears the interrupt.

An address that is rejected, whether by software or by a mismatch in hardware mode, keeps the slave silent until the next START. A data write by software while the slave is an accepted receiver raises a flag that asks for a switch to transmit.

Top module: `smb_slave_rx`

## Requirements
- R1: While `inhibit` is 1 at a START, the following address byte gets no acknowledge (SDA is not pulled low in the ninth clock) and raises no interrupt.
- R2: An address byte with direction bit (bit 0) equal to 1 (read) is not acknowledged and raises no interrupt; direction bit 0 (write) is required for receive mode.
- R3: In hardware mode (`hw_ack_en`=1) the address is ACKed (SDA low in the ninth clock) only when `((addr ^ own_addr) & addr_mask) == 0`; the interrupt rises after the ninth clock's falling edge and only for an accepted address.
- R4: In software mode, after the eighth address bit `irq` and `ack_req` rise before the ACK clock and `rx_data` holds the full address byte; the value of `ack_bit` when `irq_clr` pulses is driven in the ACK clock (1 = ACK, SDA low; 0 = NACK, SDA released).
- R5: After a rejected address, no interrupt is raised and no ACK is driven for any further byte until the next START.
- R6: In software mode each data byte of an accepted transfer raises `irq` and `ack_req` before its ACK clock, with the byte (MSB received first) in `rx_data`, and the ACK clock carries `ack_bit`.
- R7: In hardware mode each data byte is acknowledged with the `ack_bit` value preset before the byte; `irq` rises after its ACK clock with the byte in `rx_data`.
- R8: A STOP ends receive mode: `active`, `irq` and `tx_req` go to 0. Reset leaves all outputs at 0.
- R9: A `dat_wr` pulse while `active` is 1 sets `tx_req`; while not active it has no effect.
- R10: While `irq` is 1, `scl_oe` holds the clock line low; `irq` falls only on `irq_clr`, START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | 1 pulls the clock line low (stretch) |
| sda_oe | output | 1 | 1 pulls the data line low (ACK) |
| inhibit | input | 1 | 1 ignores slave addressing |
| hw_ack_en | input | 1 | 1 selects hardware acknowledge |
| own_addr | input | 7 | Programmed slave address |
| addr_mask | input | 7 | 1 bits take part in the address compare |
| ack_bit | input | 1 | Acknowledge value from software, 1 = ACK |
| irq_clr | input | 1 | Pulse clears the interrupt flag |
| dat_wr | input | 1 | Pulse marks a software write to the data register |
| irq | output | 1 | Interrupt flag |
| ack_req | output | 1 | Software acknowledge requested |
| rx_data | output | 8 | Last received byte |
| active | output | 1 | Accepted slave receiver in progress |
| tx_req | output | 1 | Switch to transmit requested |

## Verification
The bench samples the data line in the middle of every ninth clock. A design that took the acknowledge from the wrong source would show up there: the mask compare ignored, or `ack_bit` latched at the wrong moment. It would ACK a masked-off mismatch or NACK a byte that software accepted.

The bench also looks at the interrupt just before and just after each ACK clock in both modes. An engine that posted the interrupt on the wrong side of the acknowledge, or posted one in hardware mode for a rejected address, fails that check.

The directed cases cover the situations where a sloppy engine answers when it should stay silent:

- data bytes sent after a rejected address
- a read direction bit
- inhibited addressing
- a transfer with no data bytes

Randomized address, mask and mode mixes are run on top of these.

// File: rtl/smb_slave_rx.sv
module smb_slave_rx #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          inhibit,
  input  logic          hw_ack_en,
  input  logic [DW-2:0] own_addr,
  input  logic [DW-2:0] addr_mask,
  input  logic          ack_bit,
  input  logic          irq_clr,
  input  logic          dat_wr,
  output logic          irq,
  output logic          ack_req,
  output logic [DW-1:0] rx_data,
  output logic          active,
  output logic          tx_req
);
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_WAIT, S_ACK, S_IGN} st_t;

  st_t            st;
  logic [SYNC-1:0] scl_s, sda_s;
  logic           scl_q, sda_q;
  logic [DW-1:0]  sr;
  logic [CW-1:0]  cnt;
  logic           is_addr, ack_drv, acc;

  wire scl = scl_s[SYNC-1];
  wire sda = sda_s[SYNC-1];
  wire start_det = scl & scl_q & sda_q & ~sda;
  wire stop_det  = scl & scl_q & ~sda_q & sda;
  wire rise      = scl & ~scl_q;
  wire fall      = ~scl & scl_q;
  wire match     = ((sr[DW-1:1] ^ own_addr) & addr_mask) == '0;

  assign scl_oe = irq;
  assign sda_oe = (st == S_ACK) & ack_drv;
  assign active = acc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC-2:0], scl_i};
      sda_s <= {sda_s[SYNC-2:0], sda_i};
      scl_q <= scl;
      sda_q <= sda;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sr <= '0; cnt <= '0; is_addr <= 1'b0; ack_drv <= 1'b0;
      acc <= 1'b0; irq <= 1'b0; ack_req <= 1'b0; rx_data <= '0; tx_req <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; irq <= 1'b0; ack_req <= 1'b0; acc <= 1'b0; tx_req <= 1'b0;
    end else if (start_det) begin
      st <= inhibit ? S_IGN : S_SHIFT;
      cnt <= '0; is_addr <= 1'b1; irq <= 1'b0; ack_req <= 1'b0;
      acc <= 1'b0; tx_req <= 1'b0;
    end else begin
      if (dat_wr && acc) tx_req <= 1'b1;
      if (irq_clr) irq <= 1'b0;
      case (st)
        S_SHIFT:
          if (rise && cnt != CW'(DW)) begin
            sr  <= {sr[DW-2:0], sda};
            cnt <= cnt + 1'b1;
          end else if (fall && cnt == CW'(DW)) begin
            cnt     <= '0;
            rx_data <= sr;
            if (is_addr && (sr[0] || inhibit)) st <= S_IGN;
            else if (!hw_ack_en) begin
              irq <= 1'b1; ack_req <= 1'b1; st <= S_WAIT;
            end else begin
              ack_drv <= is_addr ? match : ack_bit;
              st      <= S_ACK;
            end
          end
        S_WAIT:
          if (irq_clr) begin
            ack_req <= 1'b0; ack_drv <= ack_bit; st <= S_ACK;
          end
        S_ACK:
          if (rise) cnt <= CW'(1);
          else if (fall && cnt == CW'(1)) begin
            cnt     <= '0;
            is_addr <= 1'b0;
            if (is_addr && !ack_drv) st <= S_IGN;
            else begin
              st <= S_SHIFT;
              if (is_addr) acc <= 1'b1;
              if (hw_ack_en) irq <= 1'b1;
            end
          end
        default: ;
      endcase
    end

  // R4: the acknowledge request only appears in software mode, together with the interrupt
  a_r4_ackreq_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> (irq && !$past(hw_ack_en)));

  // R5: an ignored transfer keeps the interrupt low
  a_r5_silent_ign: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !irq);

  // R3: ACK is only driven for an address byte or in an accepted transfer
  a_r3_ack_scope: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (is_addr || acc));

  // R8: a STOP returns the engine to idle
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && !irq && !acc));

  // R9: a transmit request exists only for an accepted receiver
  a_r9_txreq_active: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> acc);

  // R10: the interrupt (and clock hold) drops only on clear, START or STOP
  a_r10_irq_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(irq_clr) || $past(stop_det) || $past(start_det)));
endmodule

// File: tb/tb_smb_slave_rx.sv
module tb_smb_slave_rx;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, inhibit, hw_ack_en, ack_bit, irq_clr, dat_wr;
  logic [6:0] own_addr, addr_mask;
  logic irq, ack_req, active, tx_req;
  logic [7:0] rx_data;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  smb_slave_rx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .inhibit(inhibit), .hw_ack_en(hw_ack_en),
    .own_addr(own_addr), .addr_mask(addr_mask), .ack_bit(ack_bit),
    .irq_clr(irq_clr), .dat_wr(dat_wr), .irq(irq), .ack_req(ack_req),
    .rx_data(rx_data), .active(active), .tx_req(tx_req));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic match_f(input logic [6:0] a);
    return ((a ^ own_addr) & addr_mask) == 7'd0;
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic service();
    if (irq) begin
      irq_clr = 1'b1; waitc(1); irq_clr = 1'b0; waitc(1);
    end
  endtask

  task automatic clock_high();
    scl_m = 1'b1;
    while (!scl_line) waitc(1);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; waitc(Q);
    service();
    clock_high(); waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic start_c();
    sda_m = 1'b1; scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(Q);
  endtask

  task automatic byte_x(input logic [7:0] b, input logic is_a, input logic elig,
                        input logic ackv, input logic hw, input string tag);
    logic exp_pre, exp_post;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    exp_pre = elig && !hw;
    chk(tag, "irq before ack", irq, exp_pre);
    chk(tag, "ack_req before ack", ack_req, exp_pre);
    chk("R10", "scl hold", scl_oe, exp_pre);
    if (exp_pre) chk(tag, "rx_data", rx_data, b);
    service();
    sda_m = 1'b1; waitc(Q);
    clock_high(); waitc(Q/2);
    chk(tag, "sda in ack clock", sda_line, !(elig && ackv));
    waitc(Q/2);
    scl_m = 1'b0; waitc(Q);
    exp_post = hw && elig && (is_a ? ackv : 1'b1);
    chk(tag, "irq after ack", irq, exp_post);
    if (exp_post) begin
      chk("R10", "scl hold after ack", scl_oe, 1'b1);
      if (!is_a) chk(tag, "rx_data", rx_data, b);
    end
    service();
  endtask

  task automatic xfer(input logic [6:0] a, input logic rw, input int nd,
                      input logic hw, input logic inh, input logic addr_ack);
    logic elig, m, acc;
    string tag;
    hw_ack_en = hw; inhibit = inh;
    m    = match_f(a);
    elig = !inh && !rw;
    acc  = elig && (hw ? m : addr_ack);
    ack_bit = hw ? 1'($urandom) : addr_ack;
    start_c();
    tag = inh ? "R1" : rw ? "R2" : hw ? "R3" : "R4";
    byte_x({a, rw}, 1'b1, elig, hw ? m : addr_ack, hw, tag);
    for (int k = 0; k < nd; k++) begin
      logic [7:0] d;
      logic ab;
      d = 8'($urandom); ab = 1'($urandom);
      ack_bit = ab;
      tag = !acc ? "R5" : hw ? "R7" : "R6";
      byte_x(d, 1'b0, acc, ab, hw, tag);
    end
    chk("R8", "active before stop", active, acc);
    dat_wr = 1'b1; waitc(1); dat_wr = 1'b0; waitc(1);
    chk("R9", "tx_req after data write", tx_req, acc);
    stop_c();
    chk("R8", "active after stop", active, 1'b0);
    chk("R8", "irq after stop", irq, 1'b0);
    chk("R8", "tx_req after stop", tx_req, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    inhibit = 1'b0; hw_ack_en = 1'b1; ack_bit = 1'b1; irq_clr = 1'b0; dat_wr = 1'b0;
    own_addr = 7'h5A; addr_mask = 7'h7F;
    waitc(5); rst_n = 1'b1; waitc(5);
    chk("R8", "reset irq", irq, 1'b0);
    chk("R8", "reset scl_oe", scl_oe, 1'b0);
    chk("R8", "reset sda_oe", sda_oe, 1'b0);
    chk("R8", "reset active", active, 1'b0);
    chk("R8", "reset tx_req", tx_req, 1'b0);
    xfer(7'h5A, 1'b0, 2, 1'b1, 1'b0, 1'b1);
    xfer(7'h5B, 1'b0, 2, 1'b1, 1'b0, 1'b1);
    addr_mask = 7'h70;
    xfer(7'h53, 1'b0, 1, 1'b1, 1'b0, 1'b1);
    addr_mask = 7'h7F;
    xfer(7'h11, 1'b0, 3, 1'b0, 1'b0, 1'b1);
    xfer(7'h11, 1'b0, 2, 1'b0, 1'b0, 1'b0);
    xfer(7'h5A, 1'b0, 1, 1'b1, 1'b1, 1'b1);
    xfer(7'h5A, 1'b1, 1, 1'b1, 1'b0, 1'b1);
    xfer(7'h5A, 1'b0, 0, 1'b1, 1'b0, 1'b1);
    xfer(7'h22, 1'b0, 0, 1'b0, 1'b0, 1'b1);
    for (int t = 0; t < 30; t++) begin
      logic [6:0] a;
      own_addr  = 7'($urandom);
      addr_mask = 7'($urandom);
      a = ($urandom % 2) ? (own_addr ^ (7'($urandom) & ~addr_mask)) : 7'($urandom);
      xfer(a, ($urandom % 8) == 0, int'($urandom % 4), 1'($urandom),
           ($urandom % 8) == 0, 1'($urandom));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule